// File: doc/BRIEF.md
# Cache Range Maintenance Walker

This block turns register writes into a sequence of per-line cache maintenance requests. Software first writes the lowest address of a region with the range-start command. It then writes the highest address with one of three range-end commands, one each for clean, invalidate and clean-plus-invalidate. The end write launches a walk. The walker issues one request for every cache line whose line-aligned address lies between the two addresses, both ends included. It holds a stall output high until the cache port has acknowledged the last of those lines.

The same write port also accepts three single-line commands and an invalidate-everything command. The invalidate-everything command sweeps every set index through the same request port. A range whose two ends fall in different pages is refused with a one-cycle error pulse, because only the lower address would be translated. A range whose start lies above its end completes at once without touching the cache.

Top module: `cache_range_walker`

## Requirements
- R1: A range walk requests every line from the start line to the end line inclusive, in ascending order. Each step adds 32 bytes. The low 5 address bits of both addresses are ignored, and every request address has them at zero.
- R2: Command 3 only stores the start address and issues no request. A walk begins only on an end write: command 4 for clean, 5 for invalidate, 6 for clean-plus-invalidate.
- R3: `stall` goes high in the cycle after an accepted walk command. It stays high until the cycle after the last acknowledge.
- R4: A request holds `req_valid`, `req_addr` and `req_op` unchanged until `req_ack` is sampled high. The walker advances only on an acknowledge.
- R5: `done` is high for exactly one cycle, in the cycle after the last acknowledge, and `stall` is low in that cycle.
- R6: A range-end write whose start and end differ in any bit above the page offset (12 bits by default) raises `err` for one cycle. It issues no request and raises neither `stall` nor `done`.
- R7: `req_op` encodes the per-line operation as 1 = clean, 2 = invalidate, 3 = clean and invalidate. It follows the command that launched the walk.
- R8: Commands 0, 1 and 2 issue one request for the line holding `wr_data`, with op 1, 3 and 2 respectively.
- R9: Command 7 issues NUM_SETS invalidate requests (op 2) with `req_by_set` high. Their addresses are the set indices 0 to NUM_SETS-1 shifted left by 5.
- R10: A range-end write in one page whose start line lies above its end line issues no request. It raises `done` in the next cycle and leaves `stall` low.
- R11: Any write made while `stall` is high is ignored, including a write of a new start address.
- R12: During and right after reset, `stall`, `done`, `err` and `req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Command write strobe |
| wr_cmd | input | 3 | Command code (0-7) |
| wr_data | input | ADDR_W | Address operand of the command |
| req_valid | output | 1 | Per-line request to the cache port |
| req_addr | output | ADDR_W | Line address, or set index shifted by 5 |
| req_op | output | 2 | Per-line operation: 1 clean, 2 invalidate, 3 both |
| req_by_set | output | 1 | Address is a set index, not a memory line |
| req_ack | input | 1 | Cache port has accepted the request |
| stall | output | 1 | Requester must wait; walk in progress |
| done | output | 1 | One-cycle pulse at walk completion |
| err | output | 1 | One-cycle pulse for a page-crossing range |

## Verification
A wrong current-line register shows at once on `req_addr` at the next acknowledge. A wrong last-line register shows as an extra or a missing request, and `stall` and `done` then move on the wrong cycle. The bench varies the acknowledge latency and checks each address before acknowledging it. It confirms that `stall` drops with the `done` pulse exactly one cycle after the final acknowledge. A corrupted stored start address surfaces on the first request of the next range. A wrongly computed page test surfaces as a missing or spurious `err` pulse in the cycle after the end write.

// File: rtl/walk_pkg.sv
package walk_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_CLEAN = 2'd1,
        OP_INV   = 2'd2,
        OP_FLUSH = 2'd3
    } line_op_e;

    localparam logic [2:0] CMD_LINE_CLEAN = 3'd0;
    localparam logic [2:0] CMD_LINE_FLUSH = 3'd1;
    localparam logic [2:0] CMD_LINE_INV   = 3'd2;
    localparam logic [2:0] CMD_RANGE_LO   = 3'd3;
    localparam logic [2:0] CMD_HI_CLEAN   = 3'd4;
    localparam logic [2:0] CMD_HI_INV     = 3'd5;
    localparam logic [2:0] CMD_HI_FLUSH   = 3'd6;
    localparam logic [2:0] CMD_INV_ALL    = 3'd7;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;

endpackage

// File: rtl/walk_cmd_decode.sv
module walk_cmd_decode
    import walk_pkg::*;
(
    input  logic [2:0] cmd,
    output logic       is_lo,
    output logic       is_hi,
    output logic       is_single,
    output logic       is_all,
    output line_op_e   op
);
    always_comb begin
        is_lo     = 1'b0;
        is_hi     = 1'b0;
        is_single = 1'b0;
        is_all    = 1'b0;
        op        = OP_NONE;
        unique case (cmd)
            CMD_LINE_CLEAN: begin is_single = 1'b1; op = OP_CLEAN; end
            CMD_LINE_FLUSH: begin is_single = 1'b1; op = OP_FLUSH; end
            CMD_LINE_INV:   begin is_single = 1'b1; op = OP_INV;   end
            CMD_RANGE_LO:   begin is_lo     = 1'b1;                end
            CMD_HI_CLEAN:   begin is_hi     = 1'b1; op = OP_CLEAN; end
            CMD_HI_INV:     begin is_hi     = 1'b1; op = OP_INV;   end
            CMD_HI_FLUSH:   begin is_hi     = 1'b1; op = OP_FLUSH; end
            default:        begin is_all    = 1'b1; op = OP_INV;   end
        endcase
    end
endmodule

// File: rtl/walk_range_check.sv
module walk_range_check #(
    parameter int LINE_W = 27,
    parameter int PAGE_LINE_BITS = 7
) (
    input  logic [LINE_W-1:0] lo_line,
    input  logic [LINE_W-1:0] hi_line,
    output logic              same_page,
    output logic              empty
);
    localparam int FRAME_W = LINE_W - PAGE_LINE_BITS;

    logic [FRAME_W-1:0] lo_frame_d;
    logic [FRAME_W-1:0] hi_frame_d;

    always_comb begin
        lo_frame_d = lo_line[LINE_W-1:PAGE_LINE_BITS];
        hi_frame_d = hi_line[LINE_W-1:PAGE_LINE_BITS];
        same_page  = (lo_frame_d == hi_frame_d);
        empty      = (lo_line > hi_line);
    end
endmodule

// File: rtl/cache_range_walker.sv
module cache_range_walker
    import walk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int NUM_SETS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_cmd,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [1:0]        req_op,
    output logic              req_by_set,
    input  logic              req_ack,
    output logic              stall,
    output logic              done,
    output logic              err
);
    localparam int OFF_W          = $clog2(LINE_BYTES);
    localparam int LINE_W         = ADDR_W - OFF_W;
    localparam int PAGE_LINE_BITS = $clog2(PAGE_BYTES) - OFF_W;
    localparam logic [LINE_W-1:0] LAST_SET = LINE_W'(NUM_SETS - 1);

    typedef struct packed {
        walk_state_e       st;
        logic [LINE_W-1:0] lo;
        logic [LINE_W-1:0] cur;
        logic [LINE_W-1:0] last;
        line_op_e          op;
        logic              by_set;
        logic              done;
        logic              err;
    } walk_regs_t;

    localparam walk_regs_t RESET_VAL = '{
        st: ST_IDLE, lo: '0, cur: '0, last: '0,
        op: OP_NONE, by_set: 1'b0, done: 1'b0, err: 1'b0
    };

    walk_regs_t r_d, r_q;

    logic              dec_lo, dec_hi, dec_single, dec_all;
    line_op_e          dec_op;
    logic [LINE_W-1:0] wr_line_d;
    logic              rng_same_page, rng_empty;

    assign wr_line_d = wr_data[ADDR_W-1:OFF_W];

    walk_cmd_decode u_dec (
        .cmd       (wr_cmd),
        .is_lo     (dec_lo),
        .is_hi     (dec_hi),
        .is_single (dec_single),
        .is_all    (dec_all),
        .op        (dec_op)
    );

    walk_range_check #(
        .LINE_W         (LINE_W),
        .PAGE_LINE_BITS (PAGE_LINE_BITS)
    ) u_rng (
        .lo_line   (r_q.lo),
        .hi_line   (wr_line_d),
        .same_page (rng_same_page),
        .empty     (rng_empty)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (wr_en) begin
                    if (dec_lo) begin
                        r_d.lo = wr_line_d;
                    end else if (dec_single) begin
                        r_d.cur    = wr_line_d;
                        r_d.last   = wr_line_d;
                        r_d.op     = dec_op;
                        r_d.by_set = 1'b0;
                        r_d.st     = ST_WALK;
                    end else if (dec_all) begin
                        r_d.cur    = '0;
                        r_d.last   = LAST_SET;
                        r_d.op     = dec_op;
                        r_d.by_set = 1'b1;
                        r_d.st     = ST_WALK;
                    end else if (dec_hi) begin
                        if (!rng_same_page) begin
                            r_d.err = 1'b1;
                        end else if (rng_empty) begin
                            r_d.done = 1'b1;
                        end else begin
                            r_d.cur    = r_q.lo;
                            r_d.last   = wr_line_d;
                            r_d.op     = dec_op;
                            r_d.by_set = 1'b0;
                            r_d.st     = ST_WALK;
                        end
                    end
                end
            end
            default: begin
                if (req_ack) begin
                    if (r_q.cur == r_q.last) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.cur = r_q.cur + LINE_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign stall      = (r_q.st == ST_WALK);
    assign req_valid  = (r_q.st == ST_WALK);
    assign req_addr   = {r_q.cur, {OFF_W{1'b0}}};
    assign req_op     = r_q.op;
    assign req_by_set = r_q.by_set;
    assign done       = r_q.done;
    assign err        = r_q.err;

endmodule

// File: rtl/walk_checker.sv
module walk_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_op,
    input logic              req_ack,
    input logic              stall,
    input logic              done,
    input logic              err
);
    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) && $stable(req_op)));

    a_r1_step_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=>
        (!req_valid || (req_addr == $past(req_addr) + ADDR_W'(LINE_BYTES))));

    a_r5_done_ends_stall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !stall);

    a_r5_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(req_ack) || $past(wr_en)));

    a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!stall && !done));

    a_r3_stall_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(wr_en));
endmodule

bind cache_range_walker walk_checker #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
) u_walk_chk (.*);

// File: tb/cache_range_walker_test.sv
`timescale 1ns/1ps
module cache_range_walker_test;
    import walk_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_cmd = 3'd0;
    logic [31:0] wr_data = '0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_op;
    logic        req_by_set;
    logic        req_ack = 1'b0;
    logic        stall, done, err;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    cache_range_walker uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_op(req_op),
        .req_by_set(req_by_set), .req_ack(req_ack),
        .stall(stall), .done(done), .err(err)
    );

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [2:0]  cmd;
        logic [15:0] n;
        logic [1:0]  op;
        logic        bad_page;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_1000, 32'h0000_1000, 3'd4, 16'd1,   2'd1, 1'b0},
        '{32'h0000_2004, 32'h0000_207F, 3'd5, 16'd4,   2'd2, 1'b0},
        '{32'h0000_3F00, 32'h0000_3FE0, 3'd6, 16'd8,   2'd3, 1'b0},
        '{32'h0000_0000, 32'h0000_0FFF, 3'd4, 16'd128, 2'd1, 1'b0},
        '{32'h0000_1FE0, 32'h0000_2000, 3'd5, 16'd0,   2'd2, 1'b1},
        '{32'h0000_5080, 32'h0000_5040, 3'd4, 16'd0,   2'd1, 1'b0}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] cmd, input logic [31:0] data);
        wr_en = 1'b1; wr_cmd = cmd; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_walk(input logic [31:0] first, input int n, input logic [1:0] op,
                               input logic by_set, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [31:0] exp_a;
            exp_a = first + 32'(i * 32);
            chk(req_valid && stall, "R3 stall/valid during walk", {30'b0, req_valid, stall}, 32'h3);
            chk(req_addr == exp_a, tag, req_addr, exp_a);
            chk(req_op == op, "R7 op", 32'(req_op), 32'(op));
            chk(req_by_set == by_set, "R9 by_set", 32'(req_by_set), 32'(by_set));
            for (int w = 0; w < (i % 3); w++) begin
                @(negedge clk);
                chk(req_valid && req_addr == exp_a, "R4 hold without ack", req_addr, exp_a);
            end
            req_ack = 1'b1;
            @(negedge clk);
            req_ack = 1'b0;
        end
        chk(!stall && !req_valid, "R3 stall low after last ack", 32'(stall), 32'h0);
        chk(done, "R5 done after last ack", 32'(done), 32'h1);
        @(negedge clk);
        chk(!done, "R5 done one cycle", 32'(done), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!stall && !done && !err && !req_valid, "R12 outputs in reset",
            {28'b0, stall, done, err, req_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!stall && !done && !err && !req_valid, "R12 outputs after reset",
            {28'b0, stall, done, err, req_valid}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            write_reg(CMD_RANGE_LO, VEC[v].lo);
            write_reg(VEC[v].cmd, VEC[v].hi);
            if (VEC[v].bad_page) begin
                chk(err && !stall && !done && !req_valid, "R6 page cross rejected",
                    {28'b0, err, stall, done, req_valid}, 32'h8);
                @(negedge clk);
                chk(!err && !stall, "R6 err one cycle", 32'(err), 32'h0);
            end else if (VEC[v].n == 0) begin
                chk(done && !stall && !req_valid, "R10 empty range done",
                    {29'b0, done, stall, req_valid}, 32'h4);
                @(negedge clk);
                chk(!done && !stall, "R10 no walk", {30'b0, done, stall}, 32'h0);
            end else begin
                expect_walk(VEC[v].lo & ~32'h1F, int'(VEC[v].n), VEC[v].op, 1'b0, "R1 range addr");
            end
        end

        write_reg(CMD_RANGE_LO, 32'h0000_6000);
        repeat (3) begin
            chk(!stall && !req_valid, "R2 start write alone idle", {30'b0, stall, req_valid}, 32'h0);
            @(negedge clk);
        end

        write_reg(CMD_LINE_CLEAN, 32'h0000_8044);
        expect_walk(32'h0000_8040, 1, 2'd1, 1'b0, "R8 single clean");
        write_reg(CMD_LINE_FLUSH, 32'h0000_9000);
        expect_walk(32'h0000_9000, 1, 2'd3, 1'b0, "R8 single flush");
        write_reg(CMD_LINE_INV, 32'h0000_A01F);
        expect_walk(32'h0000_A000, 1, 2'd2, 1'b0, "R8 single inv");

        write_reg(CMD_INV_ALL, 32'h0);
        expect_walk(32'h0, 16, 2'd2, 1'b1, "R9 set sweep");

        write_reg(CMD_HI_CLEAN, 32'h0000_6040);
        write_reg(CMD_INV_ALL, 32'h0);
        write_reg(CMD_RANGE_LO, 32'h0000_7000);
        expect_walk(32'h0000_6000, 3, 2'd1, 1'b0, "R11 walk unaffected by writes");
        write_reg(CMD_HI_INV, 32'h0000_6000);
        chk(!err, "R11 start kept", 32'(err), 32'h0);
        expect_walk(32'h0000_6000, 1, 2'd2, 1'b0, "R11 start kept");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule